// File: doc/BRIEF.md
# Handshaked Sequential Floating-Point Multiplier

This block multiplies two 32-bit floating-point words. Each word stores its sign in the top bit and an 8-bit exponent with an offset of 128 below the sign. A 23-bit fraction sits in the low bits and carries an implied leading one. A client places both operands on the inputs and raises a request. The unit samples the operands and works through a short fixed pipeline of register stages. It then raises a completion flag with the product, and it holds that product until the client withdraws the request. After that it goes back to waiting.

The number system is simpler than the full IEEE one. There are no infinities, NaNs or subnormals. A product that is too large is clamped to the largest magnitude with the correct sign, and a flag marks that clamp. A product that is too small becomes zero. Any fraction bits beyond the 23 that are kept are dropped without rounding. An operand whose exponent and fraction are both zero counts as zero.

Top module: `fpm_mult`

## Requirements
- R1: Word layout is sign at bit 31, exponent at bits 30:23 with an offset of 128 (stored 128 means a scale of 2^0), and fraction at bits 22:0 with an implied leading one.
- R2: While idle, the unit waits for req. Once the rising clock edge that sees req high in idle has occurred, done is low after the next two edges and high after the third (four edges in total, including the sampling edge).
- R3: While done and req are both high, done stays high and result and ovf stay unchanged, even if op_a and op_b change.
- R4: On the first rising edge at which done is high and req is low, done goes low and the unit returns to idle.
- R5: The result sign is the XOR of the two operand signs, in every case including zero, underflow and saturation.
- R6: The 24-bit by 24-bit significand product is formed. If its bit 47 is set, the fraction is product bits 46:24. Otherwise it is bits 45:23. Lower bits are truncated.
- R7: The result exponent is ea + eb - 128, plus 1 when product bit 47 is set. A value from 0 to 255 is stored unchanged.
- R8: If the result exponent exceeds 255, the result is the sign followed by 31 ones (exponent 255, fraction all ones) and ovf is 1. Otherwise ovf is 0.
- R9: If the result exponent is below 0, bits 30:0 of the result are zero and ovf is 0.
- R10: If either operand has bits 30:0 all zero, bits 30:0 of the result are zero and ovf is 0, whatever the other operand is.
- R11: During and right after reset, done, result and ovf are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held high until done is seen |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| result | output | 32 | Product, valid while done is high |
| done | output | 1 | Completion flag |
| ovf | output | 1 | Saturation flag, valid while done is high |

## Verification
The bench raises req just after a falling edge and counts rising edges from there. It checks that done is still low after the third edge and then reads done, result and ovf after the fourth edge. This follows from the four registers on the path: the operand capture, the product, the normalisation and the packing. While req is held high, the bench checks the outputs after every further edge and changes the operands at the same time. It then drops req and expects done to be low after the very next edge. Expected products come from a bench function built from R5 to R10. The stimulus mixes seeded random operands with directed cases at the exponent limits 0, 255 and 256 and at zero operands.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int unsigned FPM_EXP_W  = 8;
  localparam int unsigned FPM_FRAC_W = 23;
  localparam int unsigned FPM_BIAS   = 128;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MUL  = 3'd1,
    ST_NORM = 3'd2,
    ST_PACK = 3'd3,
    ST_DONE = 3'd4
  } fpm_state_e;
endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic cap_en,
  output logic mul_en,
  output logic norm_en,
  output logic pack_en,
  output logic done
);
  fpm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    mul_en  = 1'b0;
    norm_en = 1'b0;
    pack_en = 1'b0;
    case (state_q)
      ST_IDLE: if (req) begin cap_en = 1'b1; state_d = ST_MUL; end
      ST_MUL:  begin mul_en  = 1'b1; state_d = ST_NORM; end
      ST_NORM: begin norm_en = 1'b1; state_d = ST_PACK; end
      ST_PACK: begin pack_en = 1'b1; state_d = ST_DONE; end
      ST_DONE: if (!req) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign done = (state_q == ST_DONE);

  // R3: completion held while the request stays up
  a_r3_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && req |=> done);
  // R4: completion released on the first edge without request
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    done && !req |=> !done);
endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul #(
  parameter int unsigned SIG_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [SIG_W-1:0]     a_sig,
  input  logic [SIG_W-1:0]     b_sig,
  output logic [2*SIG_W-1:0]   prod_q
);
  localparam int unsigned PROD_W = 2 * SIG_W;

  logic [PROD_W-1:0] prod_d;

  always_comb prod_d = PROD_W'(a_sig) * PROD_W'(b_sig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prod_q <= '0;
    else if (en) prod_q <= prod_d;
  end

  // R6: with both leading ones present, one of the top two product bits is set
  a_r6_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
    en && a_sig[SIG_W-1] && b_sig[SIG_W-1] |=> prod_q[PROD_W-1] || prod_q[PROD_W-2]);
endmodule

// File: rtl/fpm_normpack.sv
module fpm_normpack #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned BIAS   = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       norm_en,
  input  logic                       pack_en,
  input  logic                       sign_in,
  input  logic                       zero_in,
  input  logic [EXP_W-1:0]           exp_a,
  input  logic [EXP_W-1:0]           exp_b,
  input  logic [2*(FRAC_W+1)-1:0]    prod,
  output logic [EXP_W+FRAC_W:0]      result_q,
  output logic                       ovf_q
);
  localparam int unsigned SIG_W  = FRAC_W + 1;
  localparam int unsigned PROD_W = 2 * SIG_W;
  localparam int unsigned XW     = EXP_W + 3;
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam logic signed [XW-1:0] BIAS_X = XW'(BIAS);
  localparam logic signed [XW-1:0] EMAX_X = XW'((1 << EXP_W) - 1);

  // normalisation stage
  logic                  top;
  logic [FRAC_W-1:0]     frac_d, frac_n;
  logic signed [XW-1:0]  exp_d, exp_n;
  logic                  sign_n, zero_n;
  logic                  unused_low;

  assign unused_low = ^prod[PROD_W-3-FRAC_W:0];

  always_comb begin
    top    = prod[PROD_W-1];
    frac_d = top ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];
    exp_d  = $signed({3'b000, exp_a}) + $signed({3'b000, exp_b})
           + $signed({{(XW-1){1'b0}}, top}) - BIAS_X;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_n <= '0;
      exp_n  <= '0;
      sign_n <= 1'b0;
      zero_n <= 1'b0;
    end else if (norm_en) begin
      frac_n <= frac_d;
      exp_n  <= exp_d;
      sign_n <= sign_in;
      zero_n <= zero_in;
    end
  end

  // packing stage: saturate, flush or pass through
  logic [WORD_W-1:0] result_d;
  logic              ovf_d;
  logic              under, over;

  always_comb begin
    under = exp_n[XW-1];
    over  = (exp_n > EMAX_X);
    ovf_d = 1'b0;
    if (zero_n || under) begin
      result_d = {sign_n, {(WORD_W-1){1'b0}}};
    end else if (over) begin
      result_d = {sign_n, {(WORD_W-1){1'b1}}};
      ovf_d    = 1'b1;
    end else begin
      result_d = {sign_n, exp_n[EXP_W-1:0], frac_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else if (pack_en) begin
      result_q <= result_d;
      ovf_q    <= ovf_d;
    end
  end

  // R8: an exponent above the top code packs as the saturated magnitude
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    pack_en && !zero_n && !exp_n[XW-1] && (exp_n > EMAX_X)
      |=> ovf_q && (&result_q[WORD_W-2:0]));
  // R9: a negative exponent packs as zero without the flag
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    pack_en && exp_n[XW-1] |=> !ovf_q && (result_q[WORD_W-2:0] == '0));
endmodule

// File: rtl/fpm_mult.sv
module fpm_mult
  import fpm_pkg::*;
#(
  parameter int unsigned EXP_W  = FPM_EXP_W,
  parameter int unsigned FRAC_W = FPM_FRAC_W,
  parameter int unsigned BIAS   = FPM_BIAS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  done,
  output logic                  ovf
);
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned SIG_W  = FRAC_W + 1;
  localparam int unsigned PROD_W = 2 * SIG_W;

  logic cap_en, mul_en, norm_en, pack_en;
  logic [WORD_W-1:0] opa_q, opb_q;
  logic [PROD_W-1:0] prod_q;
  logic              sign_c, zero_c;

  fpm_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .cap_en  (cap_en),
    .mul_en  (mul_en),
    .norm_en (norm_en),
    .pack_en (pack_en),
    .done    (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (cap_en) begin
      opa_q <= op_a;
      opb_q <= op_b;
    end
  end

  assign sign_c = opa_q[WORD_W-1] ^ opb_q[WORD_W-1];
  assign zero_c = (opa_q[WORD_W-2:0] == '0) || (opb_q[WORD_W-2:0] == '0);

  fpm_sigmul #(.SIG_W(SIG_W)) u_sigmul (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (mul_en),
    .a_sig  ({1'b1, opa_q[FRAC_W-1:0]}),
    .b_sig  ({1'b1, opb_q[FRAC_W-1:0]}),
    .prod_q (prod_q)
  );

  fpm_normpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) u_normpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .norm_en  (norm_en),
    .pack_en  (pack_en),
    .sign_in  (sign_c),
    .zero_in  (zero_c),
    .exp_a    (opa_q[WORD_W-2 -: EXP_W]),
    .exp_b    (opb_q[WORD_W-2 -: EXP_W]),
    .prod     (prod_q),
    .result_q (result),
    .ovf_q    (ovf)
  );

  logic zero_in_a, zero_in_b;
  assign zero_in_a = (op_a[WORD_W-2:0] == '0);
  assign zero_in_b = (op_b[WORD_W-2:0] == '0);

  // R2: done rises four edges after the request is taken
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(req, 4));
  // R3: product stable while completion is held
  a_r3_stable: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> $stable(result) && $stable(ovf));
  // R5: sign follows the operands taken at the request
  a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> result[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1], 4));
  // R10: a zero operand gives a zero magnitude
  a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && $past(zero_in_a || zero_in_b, 4)
      |-> (result[WORD_W-2:0] == '0) && !ovf);
endmodule

// File: tb/fpm_mult_tb.sv
module fpm_mult_tb;
  logic        clk;
  logic        rst_n;
  logic        req;
  logic [31:0] op_a, op_b;
  logic [31:0] result;
  logic        done, ovf;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 0;

  fpm_mult u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result),
    .done   (done),
    .ovf    (ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // expected {ovf, result} from R5..R10
  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b);
    logic        s;
    logic [47:0] p;
    logic [22:0] f;
    logic        t;
    int          e;
    s = a[31] ^ b[31];
    if (a[30:0] == 31'd0 || b[30:0] == 31'd0) return {1'b0, s, 31'd0};
    p = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
    t = p[47];
    f = t ? p[46:24] : p[45:23];
    e = int'(a[30:23]) + int'(b[30:23]) - 128 + int'(t);
    if (e < 0)   return {1'b0, s, 31'd0};
    if (e > 255) return {1'b1, s, {31{1'b1}}};
    return {1'b0, s, e[7:0], f};
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int hold,
                        input string tag);
    logic [32:0] exp;
    @(negedge clk);
    op_a = a;
    op_b = b;
    req  = 1'b1;
    exp  = model(a, b);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R2 done early", 64'(done), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b1, "R2 done at fourth edge", 64'(done), 64'd1);
    check(result == exp[31:0], tag, 64'(result), 64'(exp[31:0]));
    check(ovf == exp[32], "R8 ovf flag", 64'(ovf), 64'(exp[32]));
    for (int i = 0; i < hold; i++) begin
      op_a = $urandom;
      op_b = $urandom;
      @(posedge clk);
      @(negedge clk);
      check(done && result == exp[31:0] && ovf == exp[32], "R3 hold",
            {31'd0, done, ovf, result}, {31'd0, 1'b1, exp});
    end
    req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R4 release", 64'(done), 64'd0);
  endtask

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    req   = 1'b0;
    op_a  = '0;
    op_b  = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && result == 32'd0 && ovf == 1'b0, "R11 reset",
          {31'd0, done, ovf, result}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(done == 1'b0 && result == 32'd0 && ovf == 1'b0, "R11 after reset idle",
          {31'd0, done, ovf, result}, 64'd0);
    check(done == 1'b0, "R2 idle without req", 64'(done), 64'd0);

    run_op(32'h40000000, 32'h40000000, 1, "R1 R7 one times one");
    run_op(32'h40400000, 32'h40400000, 0, "R6 top bit shift");
    run_op(32'hC0400000, 32'h40800000, 2, "R5 negative sign");
    run_op(32'hC0400000, 32'hC0800000, 0, "R5 two negatives");
    run_op(32'h7F800000, 32'h7F800000, 1, "R8 saturate");
    run_op(32'hFF800000, 32'h7F800000, 0, "R8 saturate negative");
    run_op(32'h7F800000, 32'h40000000, 0, "R7 exponent 255 kept");
    run_op(32'h7FC00000, 32'h40400000, 0, "R8 overflow through shift");
    run_op(32'h00800000, 32'h00800000, 0, "R9 underflow");
    run_op(32'h80800000, 32'h00800000, 0, "R9 underflow sign");
    run_op(32'h20400000, 32'h20000000, 0, "R9 exponent 0 kept");
    run_op(32'h00000000, 32'h7FFFFFFF, 0, "R10 zero operand a");
    run_op(32'h7FFFFFFF, 32'h80000000, 1, "R10 zero operand b sign");
    run_op(32'h3FFFFFFF, 32'h3FFFFFFF, 0, "R6 truncation");

    for (int k = 0; k < 250; k++) begin
      a = $urandom;
      b = $urandom;
      if ($urandom % 4 != 0) a[30:23] = 8'(100 + $urandom % 56);
      if ($urandom % 4 != 0) b[30:23] = 8'(100 + $urandom % 56);
      run_op(a, b, int'($urandom % 3), "R6 R7 random product");
    end
    summary();
  end
endmodule